// File: doc/BRIEF.md
# Multiply-Accumulate Datapath with Squaring Mode

This block is the arithmetic core of a small fixed-point signal processor. It holds a 16-bit x operand, a 32-bit y register built from two 16-bit halves, a 32-bit product register p and a bank of 36-bit accumulators. In each cycle a decoded control word can do three things. It can form a new product from the operands already held. It can run one ALU operation that combines an accumulator with either p or y and writes the result to an accumulator. It can also load one register half from a memory-read data port. Because each step reads only registers written at the previous edge, a load, a multiply and an accumulate in one cycle form a fetch, multiply and accumulate pipeline.

A bit in the configuration register makes every load of the upper half of y also write x. A table of samples can then be squared at one result per cycle: the accumulator receives the square of the sample fetched two cycles earlier. The instruction decoder, the memories, the wait states and saturation are outside the block. The block is driven by per-cycle control inputs and a store-data output.

Top module: `mac_sq_unit`

## Requirements
- R1: On reset, the configuration register, x, y, p, every accumulator and the three flags are all zero.
- R2: Configuration bit 0 (mirror) set: a load of the y upper half (load code 2) writes the same data into x in the same edge. With bit 0 clear, x changes only on its own load (code 1).
- R3: When mul_en is high, p takes the signed 32-bit product of the x and y upper half held before that edge. A load of x or y in the same cycle affects only the following product.
- R4: With mirror set, repeating a load of the y upper half together with mul_en and ALU op 1 (move p) into accumulator 0 leaves in accumulator 0 the square of the sample loaded two cycles earlier.
- R5: ALU ops 1, 2 and 3 write p sign-extended to 36 bits, aS + p and aS - p respectively into accumulator aD.
- R6: ALU ops 4 to 9 write y (all 32 bits, sign-extended), aS + y, aS - y, aS & y, aS | y and aS ^ y into aD.
- R7: ALU ops 10 (aS - y) and 11 (aS & y) update the flags and write no accumulator.
- R8: Every op from 1 to 11 updates the flags. Z is set for a zero result and N is result bit 35. C is the carry out of bit 35, where subtraction is done as aS + ~b + 1, so C = 1 means no borrow. C is 0 for moves and logic ops. Op 0 and codes 12 to 15 leave the flags unchanged.
- R9: Load code 4 writes the sign-extended data into bits 35:16 of the chosen accumulator. Bits 15:0 are cleared unless that accumulator's keep bit (configuration bit 1 + index) is set, in which case they are kept.
- R10: Load code 5 replaces bits 15:0 of the chosen accumulator and keeps bits 35:16.
- R11: Load code 1 writes x. Code 2 writes the y upper half and clears the lower half. Code 3 writes only the y lower half.
- R12: st_data shows, combinationally, the y upper half (st_sel 0), the y lower half (1), bits 31:16 of the chosen accumulator (2) or its bits 15:0 (3).
- R13: When an ALU write and a load target the same accumulator in one cycle, the ALU result is written and the load is dropped.
- R14: The ALU source accumulator (alu_src) and destination (alu_dst) are chosen independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write enable for the configuration register |
| cfg_wdata | input | 3 | Configuration: bit 0 mirror, bit 1+i keep low half of accumulator i |
| cfg_q | output | 3 | Current configuration |
| mul_en | input | 1 | Form p = x * y_hi this cycle |
| alu_op | input | 4 | ALU operation code (see R5 to R8) |
| alu_src | input | 1 | Source accumulator aS |
| alu_dst | input | 1 | Destination accumulator aD |
| ld_sel | input | 3 | Load code: 0 none, 1 x, 2 y upper, 3 y lower, 4 acc upper, 5 acc lower |
| ld_acc | input | 1 | Accumulator addressed by load codes 4 and 5 |
| rd_data | input | 16 | Memory-read data |
| st_sel | input | 2 | Store-data selector |
| st_acc | input | 1 | Accumulator addressed by store selectors 2 and 3 |
| st_data | output | 16 | Store data |
| x_q | output | 16 | x operand |
| y_q | output | 32 | y register, upper half in bits 31:16 |
| p_q | output | 32 | Product register |
| acc_q | output | 72 | Accumulators, accumulator i in bits 36*i+35 : 36*i |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |

## Verification
The squaring stream runs over a table that holds small positive and negative values, zero, minus one and both 16-bit extremes. A result that is one stage late or early, or an unsigned multiply, therefore yields a wrong square at a known position. Directed cycles put a multiply in the same cycle as an operand load, which shows whether p uses old or new operands. They step the ALU through every code with sources chosen so that an add, a subtract and each logic op give different values. Subtractions with equal operands and with a larger subtrahend separate the carry and borrow senses. Accumulator upper loads are tried with the keep bit clear and set after a nonzero low half, and one cycle pits an ALU write against a load on the same accumulator.

// File: rtl/mac_pkg.sv
// Shared codes for the multiply-ALU datapath.
// Assumes the control word is decoded outside; codes here are fixed.
package mac_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_P    = 4'd1,
        OP_ADDP = 4'd2,
        OP_SUBP = 4'd3,
        OP_Y    = 4'd4,
        OP_ADDY = 4'd5,
        OP_SUBY = 4'd6,
        OP_ANDY = 4'd7,
        OP_ORY  = 4'd8,
        OP_XORY = 4'd9,
        OP_CMPY = 4'd10,
        OP_TSTY = 4'd11
    } alu_op_e;

    typedef enum logic [2:0] {
        LD_NONE = 3'd0,
        LD_X    = 3'd1,
        LD_YH   = 3'd2,
        LD_YL   = 3'd3,
        LD_AH   = 3'd4,
        LD_AL   = 3'd5
    } ld_sel_e;

    localparam int CFG_MIRROR = 0;
    localparam int CFG_KEEP0  = 1;

endpackage

// File: rtl/mac_operand_regs.sv
// Operand registers x and y (two halves).
// A y upper load also writes x when mirror is set; y upper load clears y lower.
module mac_operand_regs #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      ld_sel,
    input  logic [DW-1:0]   rd_data,
    input  logic            mirror,
    output logic [DW-1:0]   x_q,
    output logic [2*DW-1:0] y_q
);
    import mac_pkg::*;

    // x register: own load, or mirrored y upper load
    always_ff @(posedge clk) begin
        if (!rst_n)
            x_q <= '0;
        else if (ld_sel == LD_X || (ld_sel == LD_YH && mirror))
            x_q <= rd_data;
    end

    // y register: upper load clears lower half, lower load keeps upper
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_q <= '0;
        else if (ld_sel == LD_YH)
            y_q <= {rd_data, {DW{1'b0}}};
        else if (ld_sel == LD_YL)
            y_q[DW-1:0] <= rd_data;
    end

endmodule

// File: rtl/mac_alu.sv
// Combinational ALU: combines accumulator aS with p or y.
// Assumes p and y are signed and are sign-extended to AW bits.
module mac_alu #(
    parameter int DW = 16,
    parameter int AW = 36
) (
    input  logic [3:0]      op,
    input  logic [AW-1:0]   a_s,
    input  logic [2*DW-1:0] p_q,
    input  logic [2*DW-1:0] y_q,
    output logic [AW-1:0]   res,
    output logic            acc_wr,
    output logic            flg_upd,
    output logic            z,
    output logic            n,
    output logic            c
);
    import mac_pkg::*;

    localparam int GW = AW - 2*DW;

    logic [AW-1:0] p_ext, y_ext, addend;
    logic          sub;
    logic          use_sum;
    logic [AW:0]   sum;

    assign p_ext = {{GW{p_q[2*DW-1]}}, p_q};
    assign y_ext = {{GW{y_q[2*DW-1]}}, y_q};

    // operand pick for the single shared adder
    always_comb begin
        addend = (op == OP_ADDP || op == OP_SUBP) ? p_ext : y_ext;
        sub    = (op == OP_SUBP || op == OP_SUBY || op == OP_CMPY);
        sum    = {1'b0, a_s} + {1'b0, (sub ? ~addend : addend)} + (AW+1)'(sub);
    end

    // result, write enable and flag update per op
    always_comb begin
        res     = '0;
        acc_wr  = 1'b1;
        flg_upd = 1'b1;
        use_sum = 1'b0;
        case (op)
            OP_P:    res = p_ext;
            OP_ADDP, OP_SUBP, OP_ADDY, OP_SUBY: begin
                res = sum[AW-1:0];
                use_sum = 1'b1;
            end
            OP_Y:    res = y_ext;
            OP_ANDY: res = a_s & y_ext;
            OP_ORY:  res = a_s | y_ext;
            OP_XORY: res = a_s ^ y_ext;
            OP_CMPY: begin
                res = sum[AW-1:0];
                use_sum = 1'b1;
                acc_wr = 1'b0;
            end
            OP_TSTY: begin
                res = a_s & y_ext;
                acc_wr = 1'b0;
            end
            default: begin
                acc_wr  = 1'b0;
                flg_upd = 1'b0;
            end
        endcase
        z = (res == '0);
        n = res[AW-1];
        c = use_sum & sum[AW];
    end

endmodule

// File: rtl/mac_acc_bank.sv
// Bank of NACC accumulators with ALU writes and half loads.
// ALU write wins over a load to the same accumulator.
module mac_acc_bank #(
    parameter int DW   = 16,
    parameter int AW   = 36,
    parameter int NACC = 2,
    parameter int IW   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_wr,
    input  logic [IW-1:0]     alu_dst,
    input  logic [AW-1:0]     alu_res,
    input  logic [2:0]        ld_sel,
    input  logic [IW-1:0]     ld_acc,
    input  logic [DW-1:0]     rd_data,
    input  logic [NACC-1:0]   keep_lo,
    output logic [NACC*AW-1:0] acc_q
);
    import mac_pkg::*;

    localparam int HW = AW - DW;

    for (genvar i = 0; i < NACC; i++) begin : g_acc
        logic [AW-1:0] a_q;
        logic          hit_alu, hit_ld;

        assign hit_alu = alu_wr && (alu_dst == IW'(i));
        assign hit_ld  = ld_acc == IW'(i);

        // one accumulator: ALU result, upper load or lower load
        always_ff @(posedge clk) begin
            if (!rst_n)
                a_q <= '0;
            else if (hit_alu)
                a_q <= alu_res;
            else if (hit_ld && ld_sel == LD_AH)
                a_q <= {{(HW-DW){rd_data[DW-1]}}, rd_data,
                        (keep_lo[i] ? a_q[DW-1:0] : {DW{1'b0}})};
            else if (hit_ld && ld_sel == LD_AL)
                a_q[DW-1:0] <= rd_data;
        end

        assign acc_q[i*AW +: AW] = a_q;
    end

endmodule

// File: rtl/mac_sq_unit.sv
// Multiply-ALU datapath top: config register, product register, flags,
// operand registers, ALU and accumulator bank. All reads see state from
// the previous edge, giving a fetch / multiply / accumulate pipeline.
module mac_sq_unit #(
    parameter int DW   = 16,
    parameter int AW   = 36,
    parameter int NACC = 2,
    localparam int IW  = (NACC > 1) ? $clog2(NACC) : 1,
    localparam int CW  = 1 + NACC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CW-1:0]      cfg_wdata,
    output logic [CW-1:0]      cfg_q,
    input  logic               mul_en,
    input  logic [3:0]         alu_op,
    input  logic [IW-1:0]      alu_src,
    input  logic [IW-1:0]      alu_dst,
    input  logic [2:0]         ld_sel,
    input  logic [IW-1:0]      ld_acc,
    input  logic [DW-1:0]      rd_data,
    input  logic [1:0]         st_sel,
    input  logic [IW-1:0]      st_acc,
    output logic [DW-1:0]      st_data,
    output logic [DW-1:0]      x_q,
    output logic [2*DW-1:0]    y_q,
    output logic [2*DW-1:0]    p_q,
    output logic [NACC*AW-1:0] acc_q,
    output logic               flag_z,
    output logic               flag_n,
    output logic               flag_c
);
    import mac_pkg::*;

    logic [AW-1:0]   a_s, a_st, alu_res;
    logic            alu_wr, flg_upd, z_d, n_d, c_d;
    logic [2*DW-1:0] prod;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= cfg_wdata;
    end

    mac_operand_regs #(.DW(DW)) u_ops (
        .clk(clk), .rst_n(rst_n), .ld_sel(ld_sel), .rd_data(rd_data),
        .mirror(cfg_q[CFG_MIRROR]), .x_q(x_q), .y_q(y_q)
    );

    assign prod = $signed(x_q) * $signed(y_q[2*DW-1:DW]);

    // product register from held operands
    always_ff @(posedge clk) begin
        if (!rst_n)
            p_q <= '0;
        else if (mul_en)
            p_q <= prod;
    end

    assign a_s = acc_q[alu_src*AW +: AW];

    mac_alu #(.DW(DW), .AW(AW)) u_alu (
        .op(alu_op), .a_s(a_s), .p_q(p_q), .y_q(y_q), .res(alu_res),
        .acc_wr(alu_wr), .flg_upd(flg_upd), .z(z_d), .n(n_d), .c(c_d)
    );

    // flag register, held on no-op codes
    always_ff @(posedge clk) begin
        if (!rst_n)
            {flag_z, flag_n, flag_c} <= '0;
        else if (flg_upd)
            {flag_z, flag_n, flag_c} <= {z_d, n_d, c_d};
    end

    mac_acc_bank #(.DW(DW), .AW(AW), .NACC(NACC), .IW(IW)) u_acc (
        .clk(clk), .rst_n(rst_n), .alu_wr(alu_wr), .alu_dst(alu_dst),
        .alu_res(alu_res), .ld_sel(ld_sel), .ld_acc(ld_acc),
        .rd_data(rd_data), .keep_lo(cfg_q[CW-1:CFG_KEEP0]), .acc_q(acc_q)
    );

    assign a_st = acc_q[st_acc*AW +: AW];

    // store-data selection
    always_comb begin
        case (st_sel)
            2'd0:    st_data = y_q[2*DW-1:DW];
            2'd1:    st_data = y_q[DW-1:0];
            2'd2:    st_data = a_st[2*DW-1:DW];
            default: st_data = a_st[DW-1:0];
        endcase
    end

endmodule

// File: rtl/mac_sq_unit_chk.sv
// Checker for mac_sq_unit, bound to every instance of the top.
// Assumes default-style codes from mac_pkg.
module mac_sq_unit_chk #(
    parameter int DW   = 16,
    parameter int AW   = 36,
    parameter int NACC = 2,
    parameter int IW   = 1,
    parameter int CW   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CW-1:0]      cfg_q,
    input logic               mul_en,
    input logic [3:0]         alu_op,
    input logic [IW-1:0]      alu_dst,
    input logic [2:0]         ld_sel,
    input logic [IW-1:0]      ld_acc,
    input logic [DW-1:0]      rd_data,
    input logic [DW-1:0]      x_q,
    input logic [2*DW-1:0]    y_q,
    input logic [2*DW-1:0]    p_q,
    input logic [NACC*AW-1:0] acc_q,
    input logic               flag_z,
    input logic               flag_n,
    input logic               flag_c
);
    localparam int GW = AW - 2*DW;

    // R2: mirrored y upper load writes x
    a_r2_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel == 3'd2 && cfg_q[0]) |=> x_q == $past(rd_data));

    // R2: x untouched without its own or a mirrored load
    a_r2_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel != 3'd1 && !(ld_sel == 3'd2 && cfg_q[0])) |=> $stable(x_q));

    // R3: product from operands held before the edge
    a_r3_product: assert property (@(posedge clk) disable iff (!rst_n)
        mul_en |=> $signed(p_q) ==
            $signed($past(x_q)) * $signed($past(y_q[2*DW-1:DW])));

    // R4: move of p into accumulator 0 takes the previous product
    a_r4_p_move: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 4'd1 && alu_dst == '0) |=>
            acc_q[AW-1:0] == {{GW{$past(p_q[2*DW-1])}}, $past(p_q)});

    // R7: compare and test leave accumulators alone
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_op == 4'd10 || alu_op == 4'd11) && ld_sel != 3'd4 && ld_sel != 3'd5)
            |=> $stable(acc_q));

    // R8: no-op keeps flags
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 4'd0 || alu_op > 4'd11) |=> $stable({flag_z, flag_n, flag_c}));

    // R9: upper load with keep bit clear zeroes the low half
    a_r9_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel == 3'd4 && ld_acc == '0 && !cfg_q[1] && !(alu_op inside {[4'd1:4'd9]} && alu_dst == '0))
            |=> acc_q[DW-1:0] == '0);

endmodule

bind mac_sq_unit mac_sq_unit_chk #(.DW(DW), .AW(AW), .NACC(NACC), .IW(IW), .CW(CW)) chk_i (.*);

// File: tb/mac_sq_unit_tb_top.sv
// Bench for mac_sq_unit: streamed squaring table, then directed cycles.
module mac_sq_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam logic [15:0] SAMP [NS] = '{16'd3, 16'hFFFC, 16'd100, 16'h8000,
                                          16'h7FFF, 16'd0, 16'hFFFF, 16'd181};
    localparam longint SQ [NS] = '{64'd9, 64'd16, 64'd10000, 64'd1073741824,
                                   64'd1073676289, 64'd0, 64'd1, 64'd32761};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_wdata, cfg_q;
    logic        mul_en;
    logic [3:0]  alu_op;
    logic        alu_src, alu_dst;
    logic [2:0]  ld_sel;
    logic        ld_acc;
    logic [15:0] rd_data;
    logic [1:0]  st_sel;
    logic        st_acc;
    logic [15:0] st_data, x_q;
    logic [31:0] y_q, p_q;
    logic [71:0] acc_q;
    logic        flag_z, flag_n, flag_c;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_sq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .mul_en(mul_en), .alu_op(alu_op), .alu_src(alu_src),
        .alu_dst(alu_dst), .ld_sel(ld_sel), .ld_acc(ld_acc), .rd_data(rd_data),
        .st_sel(st_sel), .st_acc(st_acc), .st_data(st_data), .x_q(x_q),
        .y_q(y_q), .p_q(p_q), .acc_q(acc_q), .flag_z(flag_z),
        .flag_n(flag_n), .flag_c(flag_c)
    );

    function automatic logic [63:0] e36(input longint v);
        logic [35:0] t;
        t = v[35:0];
        return {28'd0, t};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 0; cfg_wdata = 0; mul_en = 0; alu_op = 0; alu_src = 0;
        alu_dst = 0; ld_sel = 0; ld_acc = 0; rd_data = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    function automatic logic [63:0] a0();
        return {28'd0, acc_q[35:0]};
    endfunction
    function automatic logic [63:0] a1();
        return {28'd0, acc_q[71:36]};
    endfunction
    function automatic logic [63:0] flg();
        return {61'd0, flag_z, flag_n, flag_c};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        st_sel = 0; st_acc = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 cfg", {61'd0, cfg_q}, 0);
        chk("R1 x", {48'd0, x_q}, 0);
        chk("R1 y", {32'd0, y_q}, 0);
        chk("R1 p", {32'd0, p_q}, 0);
        chk("R1 acc", acc_q[63:0] | {56'd0, acc_q[71:64]}, 0);
        chk("R1 flags", flg(), 0);

        // R11: x load
        ld_sel = 1; rd_data = 16'd3; tick();
        chk("R11 x load", {48'd0, x_q}, 3);
        // R2/R11: y upper load, mirror off
        ld_sel = 2; rd_data = 16'hFFFB; tick();
        chk("R11 y upper", {32'd0, y_q}, 64'hFFFB0000);
        chk("R2 no mirror", {48'd0, x_q}, 3);
        // R3: multiply uses old x while x loads
        ld_sel = 1; rd_data = 16'd7; mul_en = 1; tick();
        chk("R3 product old operands", {32'd0, p_q}, 64'hFFFFFFF1);
        chk("R3 x new", {48'd0, x_q}, 7);
        ld_sel = 3; rd_data = 16'h1234; tick();
        chk("R11 y lower", {32'd0, y_q}, 64'hFFFB1234);

        // R5 ops on p = -15
        alu_op = 1; alu_dst = 0; tick();
        chk("R5 move p", a0(), e36(-15));
        chk("R8 flags move", flg(), 3'b010);
        alu_op = 2; alu_src = 0; alu_dst = 1; tick();
        chk("R5 R14 add p", a1(), e36(-30));
        chk("R14 src kept", a0(), e36(-15));
        chk("R8 flags add carry", flg(), 3'b011);
        alu_op = 3; alu_src = 0; alu_dst = 0; tick();
        chk("R5 sub p", a0(), 0);
        chk("R8 flags sub equal", flg(), 3'b101);

        // R6 ops on y = 0x20000
        ld_sel = 2; rd_data = 16'h0002; tick();
        alu_op = 4; alu_dst = 0; tick();
        chk("R6 move y", a0(), 64'h20000);
        alu_op = 5; alu_src = 1; alu_dst = 1; tick();
        chk("R6 add y", a1(), e36(131042));
        alu_op = 6; alu_src = 1; alu_dst = 0; tick();
        chk("R6 sub y", a0(), e36(-30));
        chk("R8 flags borrow", flg(), 3'b010);
        alu_op = 7; alu_src = 0; alu_dst = 1; tick();
        chk("R6 and y", a1(), 64'h20000);
        alu_op = 9; alu_src = 1; alu_dst = 0; tick();
        chk("R6 xor y", a0(), 0);
        chk("R8 flags logic", flg(), 3'b100);
        alu_op = 8; alu_src = 0; alu_dst = 1; tick();
        chk("R6 or y", a1(), 64'h20000);

        // R7: compare and test
        alu_op = 10; alu_src = 0; alu_dst = 0; tick();
        chk("R7 cmp flags", flg(), 3'b010);
        chk("R7 cmp no write a0", a0(), 0);
        chk("R7 cmp no write a1", a1(), 64'h20000);
        alu_op = 11; alu_src = 0; alu_dst = 1; tick();
        chk("R7 tst flags", flg(), 3'b100);
        chk("R7 tst no write", a1(), 64'h20000);
        alu_op = 13; tick();
        chk("R8 flags held", flg(), 3'b100);

        // R10/R9: accumulator half loads
        ld_sel = 5; ld_acc = 1; rd_data = 16'hABCD; tick();
        chk("R10 low load", a1(), 64'h2ABCD);
        ld_sel = 4; ld_acc = 1; rd_data = 16'h8001; tick();
        chk("R9 upper clear", a1(), 64'hF80010000);
        cfg_we = 1; cfg_wdata = 3'b100; tick();
        chk("R9 cfg", {61'd0, cfg_q}, 4);
        ld_sel = 5; ld_acc = 1; rd_data = 16'h5555; tick();
        ld_sel = 4; ld_acc = 1; rd_data = 16'h0007; tick();
        chk("R9 upper keep", a1(), 64'h000075555);
        ld_sel = 5; ld_acc = 0; rd_data = 16'h00FF; tick();
        ld_sel = 4; ld_acc = 0; rd_data = 16'h0001; tick();
        chk("R9 acc0 clear", a0(), 64'h10000);

        // R12: store selection
        st_acc = 1; st_sel = 2; #1;
        chk("R12 acc upper", {48'd0, st_data}, 16'h0007);
        st_sel = 3; #1;
        chk("R12 acc lower", {48'd0, st_data}, 16'h5555);
        st_sel = 0; #1;
        chk("R12 y upper", {48'd0, st_data}, 16'h0002);
        st_acc = 0; st_sel = 2; #1;
        chk("R12 acc0 upper", {48'd0, st_data}, 16'h0001);

        // R13: ALU write beats load
        alu_op = 1; alu_dst = 1; ld_sel = 4; ld_acc = 1; rd_data = 16'h1234; tick();
        chk("R13 alu wins", a1(), e36(-15));

        // R4/R2: squaring stream
        cfg_we = 1; cfg_wdata = 3'b001; tick();
        for (int k = 0; k < NS + 2; k++) begin
            if (k < NS) begin
                ld_sel = 2; rd_data = SAMP[k];
            end
            mul_en = 1; alu_op = 1; alu_dst = 0;
            tick();
            if (k < NS)
                chk("R2 mirror x", {48'd0, x_q}, {48'd0, SAMP[k]});
            if (k >= 2)
                chk("R4 square", a0(), e36(SQ[k-2]));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule